// File: doc/BRIEF.md
# Coincident-edge sync pulse generator

This block watches two bank clocks, bank A and bank C, that are both divided from one fast base clock by integer ratios. The ratios need not be multiples of one another. The block produces a single sync output that drops low to warn that the two bank clocks will next rise together. It rises again in the base cycle where that shared rising edge occurs. Downstream logic uses the falling edge as a one-period warning to line up transfers between the two banks.

The block takes the base clock, an active-low reset and both divide ratios. It does not generate the bank clocks. It tracks each bank's phase in base cycles, and a bank clock rises wherever its phase is zero. A freeze input parks the output low without creating runt pulses: the request only takes effect at a point where the unfrozen output would change anyway.

Top module: `coinc_sync_gen`

## Requirements
- R1: Let f be the smaller of the two ratios in use, and let a common edge be a base cycle in which both bank phases are 0 (phase = base cycles since the last restart, taken modulo the ratio). When the ratios differ, an unfrozen `sync_o` is low in exactly the f base cycles just before each common edge, and high in every other cycle.
- R2: An unfrozen `sync_o` is high in every common-edge cycle. It rises only in a common-edge cycle.
- R3: R1 and R2 hold for ratio pairs where neither ratio divides the other, such as 3 against 2 or 6 against 8.
- R4: When the two ratios are equal, an unfrozen `sync_o` is high only in common-edge cycles. It is low for the rest of each bank period.
- R5: While `rst_ni` is low, `sync_o` is high. The ratios in use are then the defaults (A = 4, C = 2), both phases are 0, and freeze is off.
- R6: At a clock edge where either ratio input differs from the ratio in use, both phases restart at 0 and the new ratios take over. The cycle after that edge counts as a common edge. `sync_o` is then held high until the next warning window, unless it is frozen.
- R7: Freeze is requested with `frz_i` = 1. The request is sampled only at an edge where the unfrozen output changes level, so the output enters freeze when it would fall and leaves freeze when it would rise. While frozen, `sync_o` is 0.
- R8: A change on `frz_i` at edges where the unfrozen output keeps its level has no effect on `sync_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast base clock common to both banks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_a_i | input | RW (5) | Bank A divide ratio, nonzero |
| ratio_c_i | input | RW (5) | Bank C divide ratio, nonzero |
| frz_i | input | 1 | Freeze request, 1 holds the output low |
| sync_o | output | 1 | Coincidence warning, low before each common edge |

## Verification
The warning window is tried with several kinds of ratio pair:
- Pairs where one ratio is a multiple of the other (2:1, 3:1, 4:1, 6:1) check that the window length follows the faster bank.
- Non-dividing pairs (3:2, 4:3, and random coprime pairs) check that exactly one window appears per least-common-multiple period, with the window in the right place.
- Equal pairs, including ratio 1, separate the one-cycle-high case from the general rule.

Mid-run ratio changes confirm the restart. Freeze requests placed on transitions and between them distinguish a sampled freeze from one applied at once.

// File: rtl/coinc_sync_pkg.sv
package coinc_sync_pkg;
  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_FALL = 2'd1,
    EV_RISE = 2'd2
  } sync_ev_e;
endpackage

// File: rtl/coinc_phase.sv
module coinc_phase #(
  parameter int RW  = 5,
  parameter int DEF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  input  logic          restart_i,
  output logic [RW-1:0] ratio_o,
  output logic          diff_o,
  output logic [RW-1:0] phase_o,
  output logic [RW-1:0] phase_nxt_o
);
  logic [RW-1:0] ratio_q, phase_q;

  assign diff_o  = (ratio_i != ratio_q);
  assign ratio_o = ratio_q;
  assign phase_o = phase_q;

  always_comb begin
    if (restart_i)                          phase_nxt_o = '0;
    else if (phase_q == ratio_q - RW'(1))   phase_nxt_o = '0;
    else                                    phase_nxt_o = phase_q + RW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RW'(DEF);
      phase_q <= '0;
    end else begin
      ratio_q <= ratio_i;
      phase_q <= phase_nxt_o;
    end
  end
endmodule

// File: rtl/coinc_window.sv
module coinc_window
  import coinc_sync_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eq_i,
  input  logic [RW-1:0] nxt_a_i,
  input  logic [RW-1:0] nxt_c_i,
  input  logic [RW-1:0] off_a_i,
  input  logic [RW-1:0] off_c_i,
  output logic          raw_o,
  output logic          raw_nxt_o,
  output sync_ev_e      ev_o
);
  logic raw_q, coinc, start;

  assign coinc = (nxt_a_i == '0) && (nxt_c_i == '0);
  // both phases at their offsets: exactly f cycles before the next common edge
  assign start = (nxt_a_i == off_a_i) && (nxt_c_i == off_c_i);

  always_comb begin
    if (coinc)      raw_nxt_o = 1'b1;
    else if (eq_i)  raw_nxt_o = 1'b0;
    else if (start) raw_nxt_o = 1'b0;
    else            raw_nxt_o = raw_q;
  end

  always_comb begin
    if (raw_nxt_o && !raw_q)      ev_o = EV_RISE;
    else if (!raw_nxt_o && raw_q) ev_o = EV_FALL;
    else                          ev_o = EV_HOLD;
  end

  assign raw_o = raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b1;
    else         raw_q <= raw_nxt_o;
  end
endmodule

// File: rtl/coinc_freeze.sv
module coinc_freeze
  import coinc_sync_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sync_ev_e ev_i,
  input  logic     raw_nxt_i,
  input  logic     frz_i,
  output logic     sync_o,
  output logic     frozen_o
);
  logic frozen_q, frozen_d, out_q;

  // freeze request is taken only where the unfrozen output changes level
  assign frozen_d = (ev_i != EV_HOLD) ? frz_i : frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b0;
      out_q    <= 1'b1;
    end else begin
      frozen_q <= frozen_d;
      out_q    <= raw_nxt_i & ~frozen_d;
    end
  end

  assign sync_o   = out_q;
  assign frozen_o = frozen_q;
endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen
  import coinc_sync_pkg::*;
#(
  parameter int RW    = 5,
  parameter int DEF_A = 4,
  parameter int DEF_C = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_a_i,
  input  logic [RW-1:0] ratio_c_i,
  input  logic          frz_i,
  output logic          sync_o
);
  localparam int NB = 2;

  logic [RW-1:0] ratio_in [NB];
  logic [RW-1:0] use_r    [NB];
  logic [RW-1:0] ph_q     [NB];
  logic [RW-1:0] ph_nxt   [NB];
  logic [RW-1:0] off      [NB];
  logic [NB-1:0] diff;
  logic          restart, eq, raw_q, raw_nxt, frozen_q;
  logic [RW-1:0] fast, pa_q, pc_q, ra_q, rc_q;
  sync_ev_e      ev;

  assign ratio_in[0] = ratio_a_i;
  assign ratio_in[1] = ratio_c_i;
  assign restart     = |diff;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    coinc_phase #(
      .RW (RW),
      .DEF((g == 0) ? DEF_A : DEF_C)
    ) u_ph (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ratio_i    (ratio_in[g]),
      .restart_i  (restart),
      .ratio_o    (use_r[g]),
      .diff_o     (diff[g]),
      .phase_o    (ph_q[g]),
      .phase_nxt_o(ph_nxt[g])
    );
    assign off[g] = use_r[g] - fast;
  end

  assign fast = (use_r[0] < use_r[1]) ? use_r[0] : use_r[1];
  assign eq   = (use_r[0] == use_r[1]);
  assign pa_q = ph_q[0];
  assign pc_q = ph_q[1];
  assign ra_q = use_r[0];
  assign rc_q = use_r[1];

  coinc_window #(.RW(RW)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eq_i     (eq),
    .nxt_a_i  (ph_nxt[0]),
    .nxt_c_i  (ph_nxt[1]),
    .off_a_i  (off[0]),
    .off_c_i  (off[1]),
    .raw_o    (raw_q),
    .raw_nxt_o(raw_nxt),
    .ev_o     (ev)
  );

  coinc_freeze u_frz (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .raw_nxt_i(raw_nxt),
    .frz_i    (frz_i),
    .sync_o   (sync_o),
    .frozen_o (frozen_q)
  );
endmodule

// File: rtl/coinc_sync_chk.sv
module coinc_sync_chk #(
  parameter int RW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_o,
  input logic          raw_q,
  input logic          frozen_q,
  input logic          restart,
  input logic [RW-1:0] pa_q,
  input logic [RW-1:0] pc_q
);
  // R2
  coinc_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_q == '0 && pc_q == '0 && !frozen_q) |-> sync_o);

  // R2
  rise_at_coinc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> (pa_q == '0 && pc_q == '0));

  // R1
  fall_with_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> !raw_q);

  // R6
  restart_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (pa_q == '0 && pc_q == '0));

  // R7
  frozen_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |-> !sync_o);

  // R8
  frz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(raw_q) |-> $stable(frozen_q));
endmodule

bind coinc_sync_gen coinc_sync_chk #(.RW(RW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_o  (sync_o),
  .raw_q   (raw_q),
  .frozen_q(frozen_q),
  .restart (restart),
  .pa_q    (pa_q),
  .pc_q    (pc_q)
);

// File: tb/sim_coinc_sync_gen.sv
module sim_coinc_sync_gen;
  localparam int RW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [RW-1:0] ratio_a_i = RW'(4);
  logic [RW-1:0] ratio_c_i = RW'(2);
  logic          frz_i = 1'b0;
  logic          sync_o;

  int n_vec = 0;
  int n_bad = 0;
  int m_a = 4, m_c = 2, m_p = 0;
  bit m_raw = 1'b1, m_frz = 1'b0, exp_o = 1'b1;
  string tag = "R5";
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  coinc_sync_gen #(.RW(RW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_a_i(ratio_a_i),
    .ratio_c_i(ratio_c_i), .frz_i(frz_i), .sync_o(sync_o)
  );

  function automatic int gcd(int x, int y);
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int lcm(int x, int y);
    return (x / gcd(x, y)) * y;
  endfunction

  // unfrozen level from the spec: high at common edge, low within f cycles before the next
  function automatic bit want_raw(int p, int a, int c);
    int l = lcm(a, c);
    int f = (a < c) ? a : c;
    return (p == 0) || ((l - p) > f);
  endfunction

  task automatic check();
    n_vec++;
    if (sync_o !== exp_o) begin
      n_bad++;
      $display("FAIL %s: sync_o=%0b expected %0b (a=%0d c=%0d phase=%0d)",
               tag, sync_o, exp_o, m_a, m_c, m_p);
    end
  endtask

  task automatic apply(int a, int c, bit f);
    bit chg, rn;
    ratio_a_i = RW'(a);
    ratio_c_i = RW'(c);
    frz_i     = f;
    chg = (a != m_a) || (c != m_c);
    if (chg) begin
      m_a = a; m_c = c; m_p = 0;
    end else begin
      m_p = (m_p + 1) % lcm(m_a, m_c);
    end
    rn = want_raw(m_p, m_a, m_c);
    if (rn != m_raw) begin
      m_frz = f;
      m_raw = rn;
    end
    exp_o = m_raw & !m_frz;
    if (chg)                                     tag = "R6";
    else if (f != m_frz)                         tag = "R8";
    else if (m_frz)                              tag = "R7";
    else if (m_a == m_c)                         tag = "R4";
    else if (m_p == 0)                           tag = "R2";
    else if ((m_a % m_c) != 0 && (m_c % m_a) != 0) tag = "R3";
    else                                         tag = "R1";
  endtask

  task automatic step(int a, int c, bit f);
    @(negedge clk_i);
    check();
    apply(a, c, f);
  endtask

  task automatic seg(int a, int c, bit f, int n);
    for (int i = 0; i < n; i++) step(a, c, f);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R5 reset state
    repeat (2) begin
      @(negedge clk_i);
      tag = "R5";
      check();
    end
    rst_ni = 1'b1;
    apply(4, 2, 1'b0);
    seg(4, 2, 1'b0, 30);     // 2:1
    seg(4, 2, 1'b0, 1);
    seg(8, 2, 1'b0, 40);     // 4:1
    seg(12, 2, 1'b0, 50);    // 6:1
    seg(2, 6, 1'b0, 40);     // 3:1
    seg(3, 2, 1'b0, 40);     // 3:2
    seg(6, 8, 1'b0, 80);     // 4:3
    seg(5, 7, 1'b0, 120);
    seg(2, 2, 1'b0, 20);     // R4 equal
    seg(7, 7, 1'b0, 30);
    seg(1, 1, 1'b0, 10);
    seg(1, 3, 1'b0, 12);
    // R7 freeze in and out, R8 short pulses between transitions
    seg(6, 8, 1'b1, 60);
    seg(6, 8, 1'b0, 60);
    for (int k = 0; k < 12; k++) begin
      step(6, 8, 1'b1);
      seg(6, 8, 1'b0, 3);
    end
    seg(3, 4, 1'b1, 15);
    step(4, 3, 1'b1);        // R6 change while frozen
    seg(4, 3, 1'b0, 40);
    for (int s = 0; s < 60; s++) begin
      int a = 1 + int'($urandom % 31);
      int c = 1 + int'($urandom % 31);
      int n = 20 + int'($urandom % 400);
      bit f = 1'b0;
      for (int i = 0; i < n; i++) begin
        if (($urandom % 24) == 0) f = ~f;
        step(a, c, f);
      end
    end
    @(negedge clk_i);
    check();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule